// File: doc/BRIEF.md
# I2C Line Conditioning Unit

This block sits between an I2C controller core and the data and clock pads. Each incoming pad line passes through a two-flop synchronizer and an optional majority-free qualifier. The qualifier only lets a new level through once three consecutive synchronized samples agree, so pulses up to two system clocks wide never reach the core. The core's serial data output can be held back by 0, 5, 10 or 15 system clocks before it reaches the pad. The pad is driven open-drain: it is pulled low for a 0 and released for a 1.

A small synchronous register port holds the line-control settings. It also holds the slave-address and data-shift registers that the controller core uses. Writes to those two registers are allowed or refused depending on the core's serial-output-enable flag.

Top module: `i2c_line_cond`

## Requirements
- R1: After reset, the line-control register reads 0x00, the data pad is released (`sda_pad_oe` = 0), and both `core_sda_i` and `core_scl_i` read 1.
- R2: Line-control bits [1:0] select the output delay. The codes 0, 1, 2 and 3 give 0, 5, 10 and 15 clocks. A change of `core_sda_o` shows at the pad exactly that many rising edges later; with code 0 it shows combinationally.
- R3: `sda_pad_oe` is 1 exactly when the delayed data bit is 0, and 0 otherwise.
- R4: With line-control bit 2 clear, a pad input level reaches the core output two rising edges after it is applied.
- R5: With line-control bit 2 set, an input pulse lasting one or two clocks never changes the core output.
- R6: With line-control bit 2 set, a level held for three clocks reaches the core output five rising edges after it is applied.
- R7: A write to offset 0x08 stores bits [7:1] as the slave address only while `serial_oe` is 0. While `serial_oe` is 1 the write is ignored. The register reads back with bit 0 as 0.
- R8: A write to offset 0x0C stores the data-shift byte only while `serial_oe` is 1. While `serial_oe` is 0 the write is ignored.
- R9: Offset 0x14 reads back bit 2 and bits [1:0] as written, and bits [7:3] read 0. Unmapped offsets read 0x00.
- R10: The clock line input is conditioned the same way as the data line input, with the same latencies and the same pulse rejection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from offset) |
| serial_oe | input | 1 | Serial-output-enable flag from the core |
| slave_addr | output | 7 | Stored slave address |
| shift_data | output | 8 | Stored data-shift byte |
| core_sda_o | input | 1 | Serial data bit from the core |
| core_sda_i | output | 1 | Conditioned data line to the core |
| core_scl_i | output | 1 | Conditioned clock line to the core |
| sda_pad_i | input | 1 | Data pad input |
| scl_pad_i | input | 1 | Clock pad input |
| sda_pad_oe | output | 1 | Data pad pull-low enable |

## Verification
Each result has a fixed latency in rising edges. The output delay shows after 0, 5, 10 or 15 edges, an unfiltered input after 2 edges, and a filtered input after 5 edges. A register write shows on the next read. The bench changes inputs on falling edges and counts exactly that many edges before it samples. It also checks that the output still holds its old value one edge early. For the pulse-rejection cases, the core output is watched on every falling edge for a window longer than the filtered latency.

// File: rtl/i2c_lc_pkg.sv
package i2c_lc_pkg;
    localparam int REG_W       = 8;
    localparam logic [7:0] OFF_SADDR = 8'h08;
    localparam logic [7:0] OFF_SHIFT = 8'h0C;
    localparam logic [7:0] OFF_LCTRL = 8'h14;
    localparam int DLY_STEP    = 5;
    localparam int DLY_CODES   = 4;
    localparam int DSEL_W      = $clog2(DLY_CODES);

    typedef struct packed {
        logic              filt_en;
        logic [DSEL_W-1:0] dsel;
    } lctrl_t;
endpackage

// File: rtl/i2c_lc_in_cond.sv
// Input conditioner for one pad line: a two-flop synchronizer followed by a
// qualifier that accepts a new level only after SAMPLES equal samples.
// Assumes the pad idles high, so every flop resets to 1.
module i2c_lc_in_cond #(
    parameter int SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_i,
    input  logic filt_en,
    output logic line_o
);
    localparam int HIST = SAMPLES - 1;

    logic            sync1, sync2;
    logic [HIST-1:0] hist;
    logic            qual;
    logic            all_hi, all_lo;

    // Two-flop synchronizer against metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= pad_i;
            sync2 <= sync1;
        end
    end

    // Sample history after the synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '1;
        else        hist <= {hist[HIST-2:0], sync2};
    end

    // Agreement of the current sample with the history.
    always_comb begin
        all_hi = sync2 & (&hist);
        all_lo = ~sync2 & ~(|hist);
    end

    // Qualified level, updated only on full agreement.
    always_ff @(posedge clk) begin
        if (!rst_n)      qual <= 1'b1;
        else if (all_hi) qual <= 1'b1;
        else if (all_lo) qual <= 1'b0;
    end

    // The bypass path adds no latency beyond the synchronizer.
    assign line_o = filt_en ? qual : sync2;
endmodule

// File: rtl/i2c_lc_out_delay.sv
// Output delay line: a shift register of STEP*(CODES-1) stages with a tap
// every STEP stages. Code 0 bypasses the register. A select change applies
// to the next clock's tap.
module i2c_lc_out_delay #(
    parameter int STEP  = 5,
    parameter int CODES = 4,
    parameter int SEL_W = $clog2(CODES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] dsel,
    input  logic             bit_i,
    output logic             bit_o
);
    localparam int DEPTH = STEP * (CODES - 1);

    logic [DEPTH-1:0] stage;
    logic [CODES-1:0] taps;

    // Shift the core bit along the line; released (1) at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) stage <= '1;
        else        stage <= {stage[DEPTH-2:0], bit_i};
    end

    assign taps[0] = bit_i;
    for (genvar t = 1; t < CODES; t++) begin : g_tap
        assign taps[t] = stage[t*STEP-1];
    end

    // Pick the tap named by the select code.
    always_comb bit_o = taps[dsel];
endmodule

// File: rtl/i2c_lc_regs.sv
// Register file: slave address, data shift and line control. Writes to the
// address and data registers are gated by the serial-output-enable flag.
// Reads are combinational from the offset.
module i2c_lc_regs
    import i2c_lc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       reg_addr,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             serial_oe,
    output logic [6:0]       slave_addr,
    output logic [REG_W-1:0] shift_data,
    output lctrl_t           lctrl
);
    logic wr_saddr, wr_shift, wr_lctrl;

    // Write strobes, with gating by the serial-output-enable flag.
    always_comb begin
        wr_saddr = reg_we && (reg_addr == OFF_SADDR) && !serial_oe;
        wr_shift = reg_we && (reg_addr == OFF_SHIFT) &&  serial_oe;
        wr_lctrl = reg_we && (reg_addr == OFF_LCTRL);
    end

    // Register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slave_addr <= '0;
            shift_data <= '0;
            lctrl      <= '0;
        end else begin
            if (wr_saddr) slave_addr <= reg_wdata[7:1];
            if (wr_shift) shift_data <= reg_wdata;
            if (wr_lctrl) lctrl      <= reg_wdata[DSEL_W:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        case (reg_addr)
            OFF_SADDR: reg_rdata = {slave_addr, 1'b0};
            OFF_SHIFT: reg_rdata = shift_data;
            OFF_LCTRL: reg_rdata = {{(REG_W-DSEL_W-1){1'b0}}, lctrl};
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_line_cond.sv
// Top of the line conditioning unit. It conditions both pad inputs, delays
// the core's data bit, drives the data pad open-drain and holds the registers.
module i2c_line_cond
    import i2c_lc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic       reg_we,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       serial_oe,
    output logic [6:0] slave_addr,
    output logic [7:0] shift_data,
    input  logic       core_sda_o,
    output logic       core_sda_i,
    output logic       core_scl_i,
    input  logic       sda_pad_i,
    input  logic       scl_pad_i,
    output logic       sda_pad_oe
);
    lctrl_t     lctrl;
    logic       sda_dly;
    logic [1:0] pads_in, lines_out;

    i2c_lc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serial_oe(serial_oe),
        .slave_addr(slave_addr), .shift_data(shift_data), .lctrl(lctrl)
    );

    assign pads_in = {scl_pad_i, sda_pad_i};
    for (genvar i = 0; i < 2; i++) begin : g_in
        i2c_lc_in_cond #(.SAMPLES(3)) u_cond (
            .clk(clk), .rst_n(rst_n), .pad_i(pads_in[i]),
            .filt_en(lctrl.filt_en), .line_o(lines_out[i])
        );
    end
    assign core_sda_i = lines_out[0];
    assign core_scl_i = lines_out[1];

    i2c_lc_out_delay #(.STEP(DLY_STEP), .CODES(DLY_CODES)) u_dly (
        .clk(clk), .rst_n(rst_n), .dsel(lctrl.dsel),
        .bit_i(core_sda_o), .bit_o(sda_dly)
    );

    // Open-drain drive: pull low only for a 0.
    assign sda_pad_oe = ~sda_dly;
endmodule

// File: rtl/i2c_line_cond_chk.sv
// Checker for i2c_line_cond, attached by bind. A cycle counter since reset
// keeps every $past lookback inside the cycles after reset.
module i2c_line_cond_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_addr,
    input logic       reg_we,
    input logic       serial_oe,
    input logic [6:0] slave_addr,
    input logic [7:0] shift_data,
    input logic       core_sda_o,
    input logic       core_sda_i,
    input logic       sda_pad_i,
    input logic       sda_pad_oe,
    input logic       filt_en,
    input logic [1:0] dsel
);
    logic [4:0] age;

    // Saturating count of cycles since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)         age <= '0;
        else if (age != 31) age <= age + 5'd1;
    end

    assert_delay5_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 5'd6 && dsel == 2'd1) |-> (sda_pad_oe == !$past(core_sda_o, 5)));

    assert_delay15_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 5'd16 && dsel == 2'd3) |-> (sda_pad_oe == !$past(core_sda_o, 15)));

    assert_bypass_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 5'd3 && !filt_en) |-> (core_sda_i == $past(sda_pad_i, 2)));

    assert_filter_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 5'd6 && filt_en && $past(filt_en) && core_sda_i != $past(core_sda_i))
        |-> ($past(sda_pad_i, 3) == core_sda_i && $past(sda_pad_i, 4) == core_sda_i
             && $past(sda_pad_i, 5) == core_sda_i));

    assert_saddr_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h08 && serial_oe) |=> $stable(slave_addr));

    assert_shift_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 8'h0C && !serial_oe) |=> $stable(shift_data));
endmodule

bind i2c_line_cond i2c_line_cond_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .serial_oe(serial_oe), .slave_addr(slave_addr), .shift_data(shift_data),
    .core_sda_o(core_sda_o), .core_sda_i(core_sda_i), .sda_pad_i(sda_pad_i),
    .sda_pad_oe(sda_pad_oe), .filt_en(lctrl.filt_en), .dsel(lctrl.dsel)
);

// File: tb/i2c_line_cond_tb.sv
module i2c_line_cond_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       serial_oe = 1'b0;
    logic [6:0] slave_addr;
    logic [7:0] shift_data;
    logic       core_sda_o = 1'b1;
    logic       core_sda_i, core_scl_i;
    logic       sda_pad_i = 1'b1;
    logic       scl_pad_i = 1'b1;
    logic       sda_pad_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    i2c_line_cond u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serial_oe(serial_oe),
        .slave_addr(slave_addr), .shift_data(shift_data),
        .core_sda_o(core_sda_o), .core_sda_i(core_sda_i),
        .core_scl_i(core_scl_i), .sda_pad_i(sda_pad_i),
        .scl_pad_i(scl_pad_i), .sda_pad_oe(sda_pad_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'h14, v);
        check("R1 lctrl", v, 8'h00);
        check("R1 oe", {7'd0, sda_pad_oe}, 8'h00);
        check("R1 sda_i", {7'd0, core_sda_i}, 8'h01);
        check("R1 scl_i", {7'd0, core_scl_i}, 8'h01);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        serial_oe = 1'b0;
        wr(8'h08, 8'hA5);
        rd(8'h08, v); check("R7 saddr write", v, 8'hA4);
        wr(8'h0C, 8'h3C);
        rd(8'h0C, v); check("R8 shift ignored", v, 8'h00);
        serial_oe = 1'b1;
        wr(8'h08, 8'h5A);
        rd(8'h08, v); check("R7 saddr ignored", v, 8'hA4);
        check("R7 saddr port", {1'b0, slave_addr}, 8'h52);
        wr(8'h0C, 8'h3C);
        rd(8'h0C, v); check("R8 shift write", v, 8'h3C);
        check("R8 shift port", shift_data, 8'h3C);
        serial_oe = 1'b0;
        wr(8'h14, 8'hFF);
        rd(8'h14, v); check("R9 lctrl fields", v, 8'h07);
        rd(8'h10, v); check("R9 unmapped", v, 8'h00);
        wr(8'h14, 8'h00);
    endtask

    task automatic t_delay(input int code);
        int dly;
        dly = code * 5;
        wr(8'h14, 8'(code));
        core_sda_o = 1'b1;
        repeat (20) @(negedge clk);
        check($sformatf("R3 released code %0d", code), {7'd0, sda_pad_oe}, 8'h00);
        core_sda_o = 1'b0;
        #1;
        if (dly == 0) begin
            check("R2 delay 0", {7'd0, sda_pad_oe}, 8'h01);
        end else begin
            repeat (dly - 1) @(negedge clk);
            check($sformatf("R2 early code %0d", code), {7'd0, sda_pad_oe}, 8'h00);
            @(negedge clk);
            check($sformatf("R2 due code %0d", code), {7'd0, sda_pad_oe}, 8'h01);
        end
        core_sda_o = 1'b1;
        repeat (20) @(negedge clk);
        check($sformatf("R3 release again %0d", code), {7'd0, sda_pad_oe}, 8'h00);
    endtask

    task automatic t_bypass();
        wr(8'h14, 8'h00);
        @(negedge clk);
        sda_pad_i = 1'b0; scl_pad_i = 1'b0;
        @(negedge clk);
        check("R4 sda early", {7'd0, core_sda_i}, 8'h01);
        check("R10 scl early", {7'd0, core_scl_i}, 8'h01);
        @(negedge clk);
        check("R4 sda due", {7'd0, core_sda_i}, 8'h00);
        check("R10 scl due", {7'd0, core_scl_i}, 8'h00);
        sda_pad_i = 1'b1; scl_pad_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_glitch(input int width);
        bit seen_sda, seen_scl;
        wr(8'h14, 8'h04);
        repeat (8) @(negedge clk);
        seen_sda = 1'b0; seen_scl = 1'b0;
        sda_pad_i = 1'b0; scl_pad_i = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (k == width - 1) begin sda_pad_i = 1'b1; scl_pad_i = 1'b1; end
            if (!core_sda_i) seen_sda = 1'b1;
            if (!core_scl_i) seen_scl = 1'b1;
        end
        check($sformatf("R5 sda pulse %0d", width), {7'd0, seen_sda}, 8'h00);
        check($sformatf("R10 scl pulse %0d", width), {7'd0, seen_scl}, 8'h00);
    endtask

    task automatic t_pass();
        wr(8'h14, 8'h04);
        repeat (8) @(negedge clk);
        sda_pad_i = 1'b0; scl_pad_i = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            if (k == 3) begin sda_pad_i = 1'b1; scl_pad_i = 1'b1; end
            if (k == 4) check("R6 sda early", {7'd0, core_sda_i}, 8'h01);
            if (k == 5) begin
                check("R6 sda due", {7'd0, core_sda_i}, 8'h00);
                check("R10 scl due", {7'd0, core_scl_i}, 8'h00);
            end
        end
        repeat (8) @(negedge clk);
        check("R6 sda recovered", {7'd0, core_sda_i}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        for (int c = 0; c < 4; c++) t_delay(c);
        t_bypass();
        t_glitch(1);
        t_glitch(2);
        t_pass();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule